// File: doc/BRIEF.md
# Three-Digit Scanned BCD Display Multiplexer

This block takes three 4-bit BCD digits, usually held in latches by a counter elsewhere, and presents them one at a time on a single shared BCD output. Three active-low strobes tell the display which digit is on the output at that moment. The display driver and the LED digits share one set of data lines, and only one digit is lit at a time.

The scanner steps on scan ticks. A ticks come either from an internal divider of the system clock or from the rising edges of an external scan input, depending on a select pin. Master reset parks the scanner on the least significant digit, turns all strobes off to blank the display, and stops scanning. The scanner is a four-state machine. `SCAN_PARK` is the reset state, with the display blanked. `SCAN_UNITS`, `SCAN_TENS` and `SCAN_HUNDS` each show one digit.

The transitions are:
- PARK to UNITS on the first cycle without reset.
- UNITS to TENS, TENS to HUNDS, and HUNDS to UNITS, each on a scan tick.
- Any state to PARK when reset is present.

Top module: `scan_mux_top`

## Requirements
- R1: While `mrst` is high, `dsel_n` is 3'b111 and `bcd_out` equals the units digit `digits_in[3:0]`. `bcd_out` follows changes of that input.
- R2: While `mrst` is high, neither external scan edges nor divider ticks move the scanner.
- R3: In the first cycle after `mrst` falls, `dsel_n` is 3'b110 and `bcd_out` shows the units digit, whatever the tick inputs are doing in that cycle.
- R4: Each scan tick advances the scanner units, then tens, then hundreds, then back to units. The strobe codes are 3'b110, 3'b101 and 3'b011 (bit i low selects digit i). The output changes in the cycle after the tick edge.
- R5: `bcd_out` equals the digit at the current position, where digit i is `digits_in[4i+3:4i]` (units i=0, tens i=1, hundreds i=2). This holds for every BCD value of every digit.
- R6: Outside reset, exactly one strobe is low at any time.
- R7: With `ext_sel` high, the scanner advances once per rising edge of `ext_scan`. A level held high does not advance it again.
- R8: With `ext_sel` low, the scanner advances every `SCAN_DIV` clock cycles and `ext_scan` has no effect.
- R9: With `ext_sel` high and no edge on `ext_scan`, the position holds however long the divider runs.
- R10: Raising `mrst` in any scan state blanks all strobes and returns the output to the units digit on the next edge. This holds even when a scan tick falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| mrst | input | 1 | Master reset, active high, synchronous |
| ext_sel | input | 1 | 1: scan on external edges, 0: scan on internal divider |
| ext_scan | input | 1 | External scan clock level |
| digits_in | input | 3*DIG_W | Three BCD digits, units in the low nibble |
| bcd_out | output | DIG_W | Currently selected BCD digit |
| dsel_n | output | 3 | Active-low digit strobes, bit 0 = units |

## Verification
Two events can fall in the same cycle: a scan tick and a change of master reset. The bench raises `mrst` at the same time as an external rising edge. It then expects the display to be blank and the output to show units, not the next digit. The bench also releases reset while `ext_scan` rises, and expects the units strobe rather than the tens strobe in the following cycle.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int NUM_DIGITS = 3;
    localparam int IDX_W      = 2;

    typedef enum logic [1:0] {
        SCAN_PARK  = 2'd0,
        SCAN_UNITS = 2'd1,
        SCAN_TENS  = 2'd2,
        SCAN_HUNDS = 2'd3
    } scan_state_e;

    typedef logic [IDX_W-1:0] digit_idx_t;

endpackage

// File: rtl/scan_tick_gen.sv
module scan_tick_gen #(
    parameter int SCAN_DIV = 1000
) (
    input  logic clk,
    input  logic mrst,
    input  logic ext_sel,
    input  logic ext_scan,
    output logic tick
);
    localparam int CNT_W = (SCAN_DIV > 2) ? $clog2(SCAN_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SCAN_DIV - 1);

    logic [CNT_W-1:0] div_cnt;
    logic             ext_prev;
    logic             div_tick;
    logic             ext_rise;

    // Free-running divider, cleared by master reset.
    always_ff @(posedge clk) begin
        if (mrst) begin
            div_cnt <= '0;
        end else if (div_cnt == CNT_LAST) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // The previous level always tracks the input, so a level already high
    // when reset ends is not taken as an edge.
    always_ff @(posedge clk) begin
        ext_prev <= ext_scan;
    end

    assign div_tick = (div_cnt == CNT_LAST);
    assign ext_rise = ext_scan & ~ext_prev;

    always_comb begin
        if (mrst) begin
            tick = 1'b0;
        end else if (ext_sel) begin
            tick = ext_rise;
        end else begin
            tick = div_tick;
        end
    end

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import scan_pkg::*;
(
    input  logic       clk,
    input  logic       mrst,
    input  logic       tick,
    output digit_idx_t sel_idx,
    output logic       blank
);
    scan_state_e state_q;
    scan_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        if (mrst) begin
            state_d = SCAN_PARK;
        end else begin
            unique case (state_q)
                SCAN_PARK:  state_d = SCAN_UNITS;
                SCAN_UNITS: state_d = tick ? SCAN_TENS  : SCAN_UNITS;
                SCAN_TENS:  state_d = tick ? SCAN_HUNDS : SCAN_TENS;
                SCAN_HUNDS: state_d = tick ? SCAN_UNITS : SCAN_HUNDS;
                default:    state_d = SCAN_PARK;
            endcase
        end
    end

    // Outputs
    always_comb begin
        sel_idx = digit_idx_t'(0);
        blank   = 1'b0;
        unique case (state_q)
            SCAN_PARK: begin
                sel_idx = digit_idx_t'(0);
                blank   = 1'b1;
            end
            SCAN_UNITS: sel_idx = digit_idx_t'(0);
            SCAN_TENS:  sel_idx = digit_idx_t'(1);
            SCAN_HUNDS: sel_idx = digit_idx_t'(2);
            default: begin
                sel_idx = digit_idx_t'(0);
                blank   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/digit_selector.sv
module digit_selector
    import scan_pkg::*;
#(
    parameter int DIG_W = 4
) (
    input  logic [NUM_DIGITS*DIG_W-1:0] digits_in,
    input  digit_idx_t                  sel_idx,
    output logic [DIG_W-1:0]            bcd_out
);
    logic [DIG_W-1:0] slot [NUM_DIGITS];

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_slot
        assign slot[g] = digits_in[g*DIG_W +: DIG_W];
    end

    always_comb begin
        bcd_out = '0;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (sel_idx == digit_idx_t'(i)) begin
                bcd_out = slot[i];
            end
        end
    end

endmodule

// File: rtl/strobe_driver.sv
module strobe_driver
    import scan_pkg::*;
(
    input  digit_idx_t            sel_idx,
    input  logic                  blank,
    output logic [NUM_DIGITS-1:0] dsel_n
);
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_strobe
        assign dsel_n[g] = blank | (sel_idx != digit_idx_t'(g));
    end

endmodule

// File: rtl/scan_mux_top.sv
module scan_mux_top
    import scan_pkg::*;
#(
    parameter int DIG_W    = 4,
    parameter int SCAN_DIV = 1000
) (
    input  logic                          clk,
    input  logic                          mrst,
    input  logic                          ext_sel,
    input  logic                          ext_scan,
    input  logic [NUM_DIGITS*DIG_W-1:0]   digits_in,
    output logic [DIG_W-1:0]              bcd_out,
    output logic [NUM_DIGITS-1:0]         dsel_n
);
    logic       tick;
    digit_idx_t sel_idx;
    logic       blank;

    scan_tick_gen #(.SCAN_DIV(SCAN_DIV)) u_tick (
        .clk      (clk),
        .mrst     (mrst),
        .ext_sel  (ext_sel),
        .ext_scan (ext_scan),
        .tick     (tick)
    );

    scan_sequencer u_seq (
        .clk     (clk),
        .mrst    (mrst),
        .tick    (tick),
        .sel_idx (sel_idx),
        .blank   (blank)
    );

    digit_selector #(.DIG_W(DIG_W)) u_sel (
        .digits_in (digits_in),
        .sel_idx   (sel_idx),
        .bcd_out   (bcd_out)
    );

    strobe_driver u_strobe (
        .sel_idx (sel_idx),
        .blank   (blank),
        .dsel_n  (dsel_n)
    );

endmodule

// File: rtl/scan_mux_chk.sv
module scan_mux_chk #(
    parameter int DIG_W = 4
) (
    input logic               clk,
    input logic               mrst,
    input logic               ext_sel,
    input logic               ext_scan,
    input logic [3*DIG_W-1:0] digits_in,
    input logic [DIG_W-1:0]   bcd_out,
    input logic [2:0]         dsel_n
);
    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    // R1
    reset_blank_chk: assert property (@(posedge clk) disable iff (!armed)
        mrst |=> (dsel_n == 3'b111));

    // R3
    release_units_chk: assert property (@(posedge clk) disable iff (!armed)
        $fell(mrst) |=> (dsel_n == 3'b110));

    // R6
    one_strobe_chk: assert property (@(posedge clk) disable iff (!armed)
        !mrst |=> ($countones(~dsel_n) == 1));

    // R4
    units_next_chk: assert property (@(posedge clk) disable iff (!armed)
        (!mrst && dsel_n == 3'b110) |=> (dsel_n == 3'b110 || dsel_n == 3'b101));

    // R5
    mux_tens_chk: assert property (@(posedge clk) disable iff (!armed)
        (dsel_n == 3'b101) |-> (bcd_out == digits_in[DIG_W +: DIG_W]));

    // R7
    ext_hold_chk: assert property (@(posedge clk) disable iff (!armed)
        (!mrst && $past(!mrst) && ext_sel && !(ext_scan && !$past(ext_scan)))
            |=> $stable(dsel_n));

endmodule

bind scan_mux_top scan_mux_chk #(.DIG_W(DIG_W)) u_chk (
    .clk       (clk),
    .mrst      (mrst),
    .ext_sel   (ext_sel),
    .ext_scan  (ext_scan),
    .digits_in (digits_in),
    .bcd_out   (bcd_out),
    .dsel_n    (dsel_n)
);

// File: tb/scan_mux_top_test.sv
module scan_mux_top_test;
    localparam int W   = 4;
    localparam int DIV = 5;

    logic           clk = 1'b0;
    logic           mrst;
    logic           ext_sel;
    logic           ext_scan;
    logic [3*W-1:0] digits;
    logic [W-1:0]   bcd;
    logic [2:0]     dsel_n;

    int nvec = 0;
    int nbad = 0;
    int pos  = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    scan_mux_top #(.DIG_W(W), .SCAN_DIV(DIV)) uut (
        .clk       (clk),
        .mrst      (mrst),
        .ext_sel   (ext_sel),
        .ext_scan  (ext_scan),
        .digits_in (digits),
        .bcd_out   (bcd),
        .dsel_n    (dsel_n)
    );

    task automatic chk(string tag, int act, int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int digit_at(int p);
        return int'(digits[p*W +: W]);
    endfunction

    task automatic check_pos(string tag);
        chk({tag, " bcd"}, int'(bcd), digit_at(pos));
        chk({tag, " strobe"}, int'(dsel_n), 7 & ~(1 << pos));
    endtask

    task automatic ext_pulse();
        @(negedge clk) ext_scan = 1'b1;
        @(negedge clk) ext_scan = 1'b0;
    endtask

    task automatic wait_change(output int n);
        logic [2:0] prev;
        prev = dsel_n;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (dsel_n == prev && n < 50);
    endtask

    initial begin
        mrst = 1'b1; ext_sel = 1'b1; ext_scan = 1'b0; digits = 12'h321;
        repeat (3) @(negedge clk);
        // R1: blanked, units shown
        chk("R1 strobe", int'(dsel_n), 7);
        chk("R1 bcd", int'(bcd), 1);
        digits = 12'h987;
        @(negedge clk);
        chk("R1 bcd follows", int'(bcd), 7);
        // R2: ticks in reset do nothing
        for (int k = 0; k < 3; k++) ext_pulse();
        chk("R2 ext strobe", int'(dsel_n), 7);
        chk("R2 ext bcd", int'(bcd), 7);
        ext_sel = 1'b0;
        repeat (3 * DIV + 1) @(negedge clk);
        chk("R2 div strobe", int'(dsel_n), 7);
        ext_sel = 1'b1;
        // R3: release
        @(negedge clk) mrst = 1'b0;
        @(negedge clk);
        pos = 0;
        check_pos("R3");
        // R4/R6: order under three patterns
        for (int pat = 0; pat < 3; pat++) begin
            digits = (pat == 0) ? 12'h450 : (pat == 1) ? 12'h999 : 12'h018;
            for (int k = 0; k < 7; k++) begin
                ext_pulse();
                pos = (pos + 1) % 3;
                check_pos("R4");
                chk("R6 one low", $countones(~dsel_n), 1);
            end
        end
        // R5: all BCD values at every position
        for (int p = 0; p < 3; p++) begin
            while (pos != p) begin
                ext_pulse();
                pos = (pos + 1) % 3;
            end
            for (int v = 0; v < 1000; v++) begin
                @(negedge clk);
                digits = {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
                #1;
                chk("R5 bcd", int'(bcd), (p == 0) ? v % 10 : (p == 1) ? (v / 10) % 10 : v / 100);
            end
        end
        digits = 12'h752;
        // R7: held level advances once
        @(negedge clk) ext_scan = 1'b1;
        repeat (6) @(negedge clk);
        pos = (pos + 1) % 3;
        check_pos("R7 held");
        ext_scan = 1'b0;
        @(negedge clk);
        check_pos("R7 fall");
        // R9: divider ignored in external mode
        repeat (3 * DIV + 2) @(negedge clk);
        check_pos("R9");
        // R8: divider mode, ext_scan toggling ignored
        ext_sel = 1'b0;
        fork
            begin
                for (int k = 0; k < 60; k++) @(negedge clk) ext_scan = ~ext_scan;
            end
            begin
                int n;
                wait_change(n);
                pos = (pos + 1) % 3;
                check_pos("R8 first");
                for (int k = 0; k < 4; k++) begin
                    wait_change(n);
                    pos = (pos + 1) % 3;
                    chk("R8 period", n, DIV);
                    check_pos("R8");
                end
            end
        join
        ext_scan = 1'b0;
        ext_sel = 1'b1;
        @(negedge clk);
        // R10: reset coinciding with an external tick
        while (pos != 2) begin
            ext_pulse();
            pos = (pos + 1) % 3;
        end
        @(negedge clk) begin mrst = 1'b1; ext_scan = 1'b1; end
        @(negedge clk) ext_scan = 1'b0;
        chk("R10 strobe", int'(dsel_n), 7);
        chk("R10 bcd", int'(bcd), 2);
        // R3: release coinciding with an external tick
        @(negedge clk) begin mrst = 1'b0; ext_scan = 1'b1; end
        @(negedge clk) ext_scan = 1'b0;
        pos = 0;
        check_pos("R3 tick at release");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nvec++;
            nbad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule